// File: doc/BRIEF.md
# Pseudo-SRAM Device Front End

This block is a synthesizable device-side model of a single-transistor pseudo-SRAM. It samples the asynchronous pins (active-low chip select, active-high power-down select, active-low write and output enables, and two active-low byte-lane enables) on a fast system clock. From these pins it decodes reads, byte-masked writes, standby and deep power down over a small parameterized word array. In place of a real tri-state bus, the data path is split into a write-data input, a read-data output and one drive-enable per byte lane.

A power-state tracker holds the device in a wait state after power is applied and again after it leaves deep power down. Deep power down wipes the array. Any access attempted before the device is ready is ignored and latches a sticky error. A separate monitor watches read traffic. It latches a sticky error when the address keeps changing faster than one read cycle for a long window, and neither a full-length cycle nor a long enough deselect pulse breaks that window. All times are parameters counted in clock cycles.

Top module: `psram_front`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `pwr_state` reads 0 (wait), `dout_oe` is 0, and both error outputs are 0. The state codes are 0 = wait, 1 = standby, 2 = active and 3 = deep power down.
- R2: With `cs2` high, the device leaves the wait state exactly `WAIT_CYC` clock edges after the wait began. An access attempted during the wait (`cs2` high, `cs1_n` low, at least one lane enable low) writes nothing and sets `err_nrdy`, which stays set until reset.
- R3: When `cs2` is low at a clock edge, the device enters deep power down (code 3) from any state. While there, no lane is driven, and every word of the array reads back as zero afterwards.
- R4: When `cs2` goes high in deep power down, the device re-enters the wait state (code 0) on the next edge. It reaches standby (code 1) after a further `WAIT_CYC` edges.
- R5: When ready, the device is in standby (code 1) whenever `cs1_n` is high or both `lb_n` and `ub_n` are high. In standby no lane is driven and the stored data is kept. When it is selected, it moves to active (code 2) on the next edge.
- R6: A write happens at the clock edge where the device is ready, `cs2` is high, `cs1_n` is low and `we_n` is low. Lane 0 (`din[7:0]`) is written only when `lb_n` is low. Lane 1 (`din[15:8]`) is written only when `ub_n` is low.
- R7: With the device ready and selected, `we_n` high and `oe_n` low, `dout_oe[0]` follows the inverse of `lb_n` and `dout_oe[1]` follows the inverse of `ub_n`. The driven lanes of `dout` carry the word stored at `addr`.
- R8: With `we_n` high and `oe_n` high, `dout_oe` is 0 even while the chip is selected.
- R9: During reads, an address change after fewer than `TRC_CYC` cycles at the old address starts an abnormal run. When the run reaches `WIN_CYC` read cycles, `err_tmg` is set and stays set until reset.
- R10: An abnormal run is cleared when a read address is held for `TRC_CYC` cycles, or when `cs1_n` stays high for `TRC_CYC` consecutive cycles. Patterns broken this way never set `err_tmg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low reset, models power being applied |
| cs1_n | input | 1 | Active-low chip select |
| cs2 | input | 1 | High for normal operation, low for deep power down |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| lb_n | input | 1 | Active-low enable of byte lane 0 |
| ub_n | input | 1 | Active-low enable of byte lane 1 |
| addr | input | AW | Word address |
| din | input | 16 | Write data |
| dout | output | 16 | Read data of the word at `addr` |
| dout_oe | output | 2 | Per-lane drive enable, bit 0 for lane 0 |
| pwr_state | output | 2 | Power state code |
| err_nrdy | output | 1 | Sticky flag for an access during a wait |
| err_tmg | output | 1 | Sticky flag for abnormal read timing |

## Verification
The hardest condition to reach from the pins is the timing error. It needs tens of consecutive read cycles with the address toggling at a controlled period, interleaved with deselect pulses whose lengths sit exactly at the threshold and one cycle short of it. The bench drives address periods of 2, 3 and 4 cycles, and deselect pulses of 4 and 3 cycles, with a fresh reset before each pattern. This puts the boundaries on both sides of `TRC_CYC`. The array wipe is reached by writing known data, entering and leaving deep power down, attempting a write inside the exit wait, and then reading every address back.

// File: rtl/psram_pkg.sv
package psram_pkg;
   typedef enum logic [1:0] {
      PS_WAIT = 2'd0,
      PS_STBY = 2'd1,
      PS_ACT  = 2'd2,
      PS_DPD  = 2'd3
   } pwr_e;
   localparam int unsigned LANE_W = 8;
   localparam int unsigned LANES  = 2;
   localparam int unsigned WORD_W = LANE_W * LANES;
endpackage

// File: rtl/psram_pwr.sv
module psram_pwr
   import psram_pkg::*;
#(
   parameter int unsigned WAIT_CYC = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs2,
   input  logic sel,
   output pwr_e state
);
   localparam int unsigned CW = $clog2(WAIT_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

   generate
      if (WAIT_CYC < 1) begin : g_bad_wait
         $error("WAIT_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PS_WAIT;
         cnt   <= '0;
      end else begin
         unique case (state)
            PS_WAIT: begin
               if (!cs2) begin
                  state <= PS_DPD;
                  cnt   <= '0;
               end else if (cnt == LAST) begin
                  state <= PS_STBY;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PS_STBY, PS_ACT: begin
               if (!cs2)     state <= PS_DPD;
               else if (sel) state <= PS_ACT;
               else          state <= PS_STBY;
            end
            PS_DPD: begin
               if (cs2) begin
                  state <= PS_WAIT;
                  cnt   <= '0;
               end
            end
            default: state <= PS_WAIT;
         endcase
      end
   end

   a_r3_dpd_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (state != PS_DPD && !cs2) |=> state == PS_DPD);
   a_r4_dpd_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_DPD && cs2) |=> state == PS_WAIT);
   a_r2_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_DPD) |=> state != PS_STBY && state != PS_ACT);
endmodule

// File: rtl/psram_array.sv
module psram_array
   import psram_pkg::*;
#(
   parameter int unsigned AW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wipe,
   input  logic              wr_en,
   input  logic [LANES-1:0]  wr_lane,
   input  logic [AW-1:0]     addr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   generate
      if (AW < 1 || AW > 10) begin : g_bad_aw
         $error("AW must lie in 1..10");
      end
   endgenerate

   logic [WORD_W-1:0] mem [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem[w][l*LANE_W +: LANE_W] <= '0;
            end else if (wipe) begin
               mem[w][l*LANE_W +: LANE_W] <= '0;
            end else if (wr_en && wr_lane[l] && addr == AW'(w)) begin
               mem[w][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
            end
         end
      end
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/psram_tmon.sv
module psram_tmon #(
   parameter int unsigned AW      = 4,
   parameter int unsigned TRC_CYC = 4,
   parameter int unsigned WIN_CYC = 30
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reading,
   input  logic          cs1_n,
   input  logic [AW-1:0] addr,
   output logic          err
);
   localparam int unsigned HW = $clog2(TRC_CYC + 1);
   localparam int unsigned RW = $clog2(WIN_CYC + 1);
   localparam logic [HW-1:0] TRC = HW'(TRC_CYC);
   localparam logic [RW-1:0] WIN = RW'(WIN_CYC);

   generate
      if (TRC_CYC < 2) begin : g_bad_trc
         $error("TRC_CYC must be at least 2");
      end
      if (WIN_CYC < TRC_CYC) begin : g_bad_win
         $error("WIN_CYC must not be below TRC_CYC");
      end
   endgenerate

   logic [AW-1:0] addr_q;
   logic [HW-1:0] hold;
   logic [HW-1:0] dcnt;
   logic [RW-1:0] run;
   logic          chg;
   logic          short_chg;
   logic          full_cyc;
   logic          long_desel;

   assign chg        = (addr != addr_q);
   assign short_chg  = reading && chg && (hold < TRC);
   assign full_cyc   = reading && (hold >= TRC);
   assign long_desel = cs1_n && (dcnt == TRC - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         hold   <= TRC;
         dcnt   <= '0;
         run    <= '0;
         err    <= 1'b0;
      end else begin
         addr_q <= addr;
         if (chg)              hold <= HW'(1);
         else if (hold != TRC) hold <= hold + 1'b1;
         if (!cs1_n)           dcnt <= '0;
         else if (dcnt != TRC) dcnt <= dcnt + 1'b1;
         if (long_desel || full_cyc) begin
            run <= '0;
         end else if ((short_chg || (reading && run != '0)) && run != WIN) begin
            run <= run + 1'b1;
         end
         if (run >= WIN) err <= 1'b1;
      end
   end

   a_r9_tmg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   a_r10_run_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      long_desel |=> run == '0);
endmodule

// File: rtl/psram_front.sv
module psram_front
   import psram_pkg::*;
#(
   parameter int unsigned AW       = 4,
   parameter int unsigned WAIT_CYC = 20,
   parameter int unsigned TRC_CYC  = 4,
   parameter int unsigned WIN_CYC  = 30
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs1_n,
   input  logic          cs2,
   input  logic          we_n,
   input  logic          oe_n,
   input  logic          lb_n,
   input  logic          ub_n,
   input  logic [AW-1:0] addr,
   input  logic [15:0]   din,
   output logic [15:0]   dout,
   output logic [1:0]    dout_oe,
   output logic [1:0]    pwr_state,
   output logic          err_nrdy,
   output logic          err_tmg
);
   generate
      if (WORD_W != 16) begin : g_bad_word
         $error("pin data bus is fixed at 16 bits");
      end
   endgenerate

   pwr_e             state;
   logic [LANES-1:0] lane_n;
   logic             sel;
   logic             ready;
   logic             live;
   logic             wr_en;
   logic             attempt;
   logic [15:0]      rd_word;

   assign lane_n  = {ub_n, lb_n};
   assign sel     = !cs1_n && !(&lane_n);
   assign ready   = (state == PS_STBY) || (state == PS_ACT);
   assign live    = ready && cs2 && sel;
   assign wr_en   = live && !we_n;
   assign attempt = (state == PS_WAIT) && cs2 && sel;

   psram_pwr #(.WAIT_CYC(WAIT_CYC)) i_pwr (
      .clk   (clk),
      .rst_n (rst_n),
      .cs2   (cs2),
      .sel   (sel),
      .state (state)
   );

   psram_array #(.AW(AW)) i_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wipe    (state == PS_DPD),
      .wr_en   (wr_en),
      .wr_lane (~lane_n),
      .addr    (addr),
      .wdata   (din),
      .rdata   (rd_word)
   );

   psram_tmon #(.AW(AW), .TRC_CYC(TRC_CYC), .WIN_CYC(WIN_CYC)) i_tmon (
      .clk     (clk),
      .rst_n   (rst_n),
      .reading (live && we_n),
      .cs1_n   (cs1_n),
      .addr    (addr),
      .err     (err_tmg)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_drive
      assign dout_oe[l] = live && we_n && !oe_n && !lane_n[l];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err_nrdy <= 1'b0;
      else if (attempt) err_nrdy <= 1'b1;
   end

   assign dout      = rd_word;
   assign pwr_state = state;

   a_r3_dpd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_DPD) |-> dout_oe == 2'b00);
   a_r3_wiped: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == PS_DPD) |-> rd_word == 16'h0000);
   a_r5_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cs1_n |-> dout_oe == 2'b00);
   a_r2_nrdy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_nrdy |=> err_nrdy);
   a_r2_wait_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_WAIT) |-> !wr_en);
endmodule

// File: tb/test_psram_front.sv
`timescale 1ns/1ps
module test_psram_front;
   localparam int AW       = 4;
   localparam int DEPTH    = 1 << AW;
   localparam int WAIT_CYC = 20;
   localparam int TRC_CYC  = 4;
   localparam int WIN_CYC  = 30;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs1_n = 1'b1, cs2 = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic          lb_n = 1'b0, ub_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [15:0]   din = '0;
   logic [15:0]   dout;
   logic [1:0]    dout_oe;
   logic [1:0]    pwr_state;
   logic          err_nrdy, err_tmg;

   int checks = 0;
   int errors = 0;
   logic [15:0] mdl [DEPTH];

   always #10 clk = ~clk;

   psram_front #(.AW(AW), .WAIT_CYC(WAIT_CYC), .TRC_CYC(TRC_CYC), .WIN_CYC(WIN_CYC)) i_psram_front (
      .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .we_n(we_n), .oe_n(oe_n),
      .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .din(din), .dout(dout),
      .dout_oe(dout_oe), .pwr_state(pwr_state), .err_nrdy(err_nrdy), .err_tmg(err_tmg)
   );

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic idle();
      cs1_n = 1'b1; cs2 = 1'b1; we_n = 1'b1; oe_n = 1'b1; lb_n = 1'b0; ub_n = 1'b0;
   endtask

   task automatic do_reset();
      idle();
      rst_n = 1'b0;
      tick(); tick();
      #1;
      chk("R1 state", 32'(pwr_state), 32'd0);
      chk("R1 oe", 32'(dout_oe), 32'd0);
      chk("R1 errs", 32'({err_nrdy, err_tmg}), 32'd0);
      rst_n = 1'b1;
      for (int w = 0; w < DEPTH; w++) mdl[w] = '0;
      tick();
      chk("R1 state after release", 32'(pwr_state), 32'd0);
      for (int i = 1; i < WAIT_CYC; i++) tick();
      chk("R2 ready", 32'(pwr_state), 32'd1);
   endtask

   task automatic wr(input int a, input logic [15:0] d, input logic l_n, input logic u_n);
      addr = AW'(a); din = d; lb_n = l_n; ub_n = u_n; cs1_n = 1'b0; we_n = 1'b0;
      tick();
      if (!l_n) mdl[a][7:0]  = d[7:0];
      if (!u_n) mdl[a][15:8] = d[15:8];
      we_n = 1'b1; cs1_n = 1'b1;
   endtask

   task automatic rd(input string req, input int a, input logic l_n, input logic u_n, input logic o_n);
      logic [1:0]  eoe;
      logic [15:0] m;
      addr = AW'(a); lb_n = l_n; ub_n = u_n; oe_n = o_n; we_n = 1'b1; cs1_n = 1'b0;
      #1;
      eoe = o_n ? 2'b00 : {~u_n, ~l_n};
      m = {{8{eoe[1]}}, {8{eoe[0]}}};
      chk(req, 32'(dout_oe), 32'(eoe));
      if (eoe != 2'b00) chk(req, 32'(dout & m), 32'(mdl[a] & m));
      cs1_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic toggle(input string req, input int period, input int plen, input int cycles, input logic exp);
      do_reset();
      we_n = 1'b1; oe_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0; cs1_n = 1'b0;
      for (int i = 0; i < cycles; i++) begin
         if (i % period == 0) addr = addr ^ AW'(1);
         cs1_n = (plen > 0) && ((i % 16) >= (16 - plen));
         tick();
      end
      idle();
      #1;
      chk(req, 32'(err_tmg), 32'(exp));
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1 and R2: reset state and exact wait length
      idle();
      rst_n = 1'b0;
      tick();
      #1;
      chk("R1 state", 32'(pwr_state), 32'd0);
      chk("R1 oe", 32'(dout_oe), 32'd0);
      chk("R1 errs", 32'({err_nrdy, err_tmg}), 32'd0);
      rst_n = 1'b1;
      for (int i = 0; i < WAIT_CYC - 1; i++) tick();
      chk("R2 still waiting", 32'(pwr_state), 32'd0);
      tick();
      chk("R2 ready at limit", 32'(pwr_state), 32'd1);
      for (int w = 0; w < DEPTH; w++) mdl[w] = '0;

      // R6 R7: full-word writes and reads over all addresses
      for (int a = 0; a < DEPTH; a++) wr(a, 16'(a * 16'h1111) ^ 16'h5A3C, 1'b0, 1'b0);
      for (int a = 0; a < DEPTH; a++) rd("R7 full read", a, 1'b0, 1'b0, 1'b0);

      // R6 R7 R8 R5: every lane mask on write, every lane mask and oe on read
      for (int a = 0; a < DEPTH; a++) begin
         for (int mw = 0; mw < 3; mw++) begin
            wr(a, {8'(a * 7 + mw), 8'(a * 13 + mw * 3 + 1)}, mw[0], mw[1]);
            for (int mr = 0; mr < 4; mr++) begin
               rd("R6 R7 masked", a, mr[0], mr[1], 1'b0);
               rd("R8 oe high", a, mr[0], mr[1], 1'b1);
            end
         end
      end

      // R5: standby versus active
      idle(); oe_n = 1'b0;
      #1;
      chk("R5 deselected quiet", 32'(dout_oe), 32'd0);
      tick();
      chk("R5 standby code", 32'(pwr_state), 32'd1);
      cs1_n = 1'b0; lb_n = 1'b1; ub_n = 1'b1;
      #1;
      chk("R5 no lanes quiet", 32'(dout_oe), 32'd0);
      tick();
      chk("R5 no lanes standby", 32'(pwr_state), 32'd1);
      lb_n = 1'b0;
      tick();
      chk("R5 active code", 32'(pwr_state), 32'd2);
      idle();
      tick();
      for (int a = 0; a < DEPTH; a++) rd("R5 data kept", a, 1'b0, 1'b0, 1'b0);
      chk("R9 no timing error in sweep", 32'(err_tmg), 32'd0);
      chk("R2 no nrdy in sweep", 32'(err_nrdy), 32'd0);

      // R3 R4: deep power down, wipe, exit wait, ignored access
      cs2 = 1'b0;
      tick();
      chk("R3 dpd code", 32'(pwr_state), 32'd3);
      cs1_n = 1'b0; oe_n = 1'b0;
      #1;
      chk("R3 dpd quiet", 32'(dout_oe), 32'd0);
      idle(); cs2 = 1'b1;
      tick();
      chk("R4 exit to wait", 32'(pwr_state), 32'd0);
      addr = AW'(5); din = 16'hABCD; cs1_n = 1'b0; we_n = 1'b0;
      tick();
      idle();
      #1;
      chk("R2 nrdy set", 32'(err_nrdy), 32'd1);
      for (int i = 0; i < WAIT_CYC - 2; i++) tick();
      chk("R4 still waiting", 32'(pwr_state), 32'd0);
      tick();
      chk("R4 standby after wait", 32'(pwr_state), 32'd1);
      for (int w = 0; w < DEPTH; w++) mdl[w] = '0;
      for (int a = 0; a < DEPTH; a++) rd("R3 wiped and R2 write ignored", a, 1'b0, 1'b0, 1'b0);
      tick();
      chk("R2 nrdy sticky", 32'(err_nrdy), 32'd1);

      // R9 R10: abnormal read timing
      toggle("R9 period 2 flags", 2, 0, 80, 1'b1);
      toggle("R9 period 3 flags", 3, 0, 120, 1'b1);
      toggle("R10 period 4 clean", 4, 0, 200, 1'b0);
      toggle("R10 deselect pulse 4 clears", 2, 4, 160, 1'b0);
      toggle("R9 deselect pulse 3 too short", 2, 3, 160, 1'b1);
      tick();
      chk("R9 timing error sticky", 32'(err_tmg), 32'd1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule